// File: doc/BRIEF.md
# System Status and Interval Timer Register Bank

This block is the small register bank that a processor support chip keeps beside its memory controller. It holds a halt-code word, a memory error status register, a read-only failing-address register, a self-test LED word, a parity control word and a 16-bit interval timer. Software reaches the bank through a simple synchronous bus with a request strobe, a write flag, a byte address and a size qualifier. The register is chosen by the longword index `(address - base) >> 2`. Read data is registered and appears one cycle after the request.

The error status register mixes three kinds of bit. Two control bits can be read and written. A parity-error flag is set by hardware and cleared by writing one to it. A memory-code bit is fixed by a parameter. A pulse on the error-capture input sets the flag and latches the failing longword address in the same cycle.

The interval timer advances on a microsecond tick enable. Each period lasts the two's complement of a 16-bit load value, and a load of zero gives the longest period. When a period ends, the timer pulses an expiry output and starts the next period. Reading the timer returns the two's complement of the time remaining, so the value counts up towards wrap.

Top module: `sys_status_timer`

## Requirements
- R1: The register index is `bus_addr[IDX_W+1:2]`, and the bank is hit only when the address bits above that field equal those of `BASE_ADDR`. Index 0 is halt code, 1 is error status, 2 is failing address, 4 is LEDs, 5 is parity control and 7 is the timer. Indices 3 and 6, and any miss, read as zero and ignore writes. A read returns its data on `bus_rdata` in the cycle after the request.
- R2: `bus_size` selects the written byte lanes: 0 = byte (lane `bus_addr[1:0]`), 1 = word (lanes 3:2 when `bus_addr[1]` is 1, else lanes 1:0), 2 or 3 = longword (all lanes). Write data is lane-aligned (lane n is bits 8n+7:8n), and only the selected lanes change.
- R3: The error status register reads back bit 0 (parity enable), bit 1 (write wrong parity), bit 6 (parity error) and bit 8 (memory code, fixed to parameter `MEM_CODE0`). Every other bit reads 0.
- R4: A write to the error status register changes only bits 0 and 1. Writing 1 to bit 6 clears the parity-error flag, and writing 0 to bit 6 leaves it as it is.
- R5: An `err_capture` pulse sets the parity-error flag and loads `err_addr` into the failing-address register. If a write-one-to-clear lands in the same cycle, the capture wins.
- R6: The failing-address register reads its 15 bits in bits 14:0, with zeros above, and ignores writes.
- R7: Halt code, LEDs and parity control are 32-bit read/write registers.
- R8: A timer write stores bits 31:16 of the write data, in the selected lanes, as the load value. The period in progress is not changed.
- R9: A new period lasts `(-load) mod 2^16` ticks, or 0xFFFF ticks when the load is zero. The stored load is cleared to zero when a period starts. Without a reload, later periods are 0xFFFF ticks long.
- R10: A timer read returns `(-remaining) mod 2^16` in bits 31:16 and zero in bits 15:0.
- R11: `tmr_expire` is high for exactly one cycle after the tick that ends a period.
- R12: Reset clears halt code, error bits 0, 1 and 6, the failing address, the LEDs and parity control. It also starts a 0xFFFF-tick period with a zero load, so the timer first reads 0x0001_0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | 0 byte, 1 word, 2/3 longword |
| bus_wdata | input | 32 | Lane-aligned write data |
| bus_rdata | output | 32 | Registered read data |
| err_capture | input | 1 | Memory error capture pulse |
| err_addr | input | FAR_W | Failing longword address to latch |
| us_tick | input | 1 | Microsecond tick enable |
| tmr_expire | output | 1 | One-cycle period expiry pulse |

## Verification
The assertions assume that reset is high from time zero. They also assume that a request stays up for only one cycle at a time, so the index of the request in the previous cycle says what `bus_rdata` holds now. The stimulus drives every request for exactly one cycle on the falling edge and drops it before the next. It holds `us_tick` low during the random register traffic, so the timer reading stays fixed there. Ticks are then applied in long, directed runs that reach both a full 0xFFFF period and a short reloaded one.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LNG2 = 2'd3
  } bus_size_e;

  // Longword indices inside the bank
  localparam int REG_HALT  = 0;
  localparam int REG_MSE   = 1;
  localparam int REG_FAR   = 2;
  localparam int REG_LED   = 4;
  localparam int REG_PCTL  = 5;
  localparam int REG_TIMER = 7;

  // Error status bit positions
  localparam int MSE_PE   = 0;
  localparam int MSE_WWP  = 1;
  localparam int MSE_PER  = 6;
  localparam int MSE_MCD0 = 8;

  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic [DATA_W-1:0] mask
  );
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/sst_lane_mask.sv
module sst_lane_mask import sst_pkg::*; (
  input  logic [1:0]        size,
  input  logic [1:0]        addr_lo,
  output logic [LANES-1:0]  lane_en,
  output logic [DATA_W-1:0] bit_mask
);
  always_comb begin
    unique case (bus_size_e'(size))
      SZ_BYTE: lane_en = LANES'(1) << addr_lo;
      SZ_WORD: lane_en = addr_lo[1] ? 4'b1100 : 4'b0011;
      default: lane_en = '1;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bit_mask[8*g +: 8] = {8{lane_en[g]}};
  end
endmodule

// File: rtl/sst_err_bank.sv
module sst_err_bank import sst_pkg::*; #(
  parameter int   FAR_W     = 15,
  parameter logic MEM_CODE0 = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] wmask,
  input  logic              capture,
  input  logic [FAR_W-1:0]  cap_addr,
  output logic [DATA_W-1:0] mse_value,
  output logic [DATA_W-1:0] far_value,
  output logic              per_flag
);
  logic pe_q, wwp_q, per_q;
  logic [FAR_W-1:0] far_q;
  logic clr_per;

  assign clr_per = wr_en && wmask[MSE_PER] && wdata[MSE_PER];

  always_ff @(posedge clk) begin
    if (rst) begin
      pe_q  <= 1'b0;
      wwp_q <= 1'b0;
      per_q <= 1'b0;
      far_q <= '0;
    end else begin
      if (wr_en && wmask[MSE_PE])  pe_q  <= wdata[MSE_PE];
      if (wr_en && wmask[MSE_WWP]) wwp_q <= wdata[MSE_WWP];
      if (capture) begin
        per_q <= 1'b1;
        far_q <= cap_addr;
      end else if (clr_per) begin
        per_q <= 1'b0;
      end
    end
  end

  always_comb begin
    mse_value           = '0;
    mse_value[MSE_PE]   = pe_q;
    mse_value[MSE_WWP]  = wwp_q;
    mse_value[MSE_PER]  = per_q;
    mse_value[MSE_MCD0] = MEM_CODE0;
    far_value           = DATA_W'(far_q);
  end

  assign per_flag = per_q;
endmodule

// File: rtl/sst_interval_timer.sv
module sst_interval_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_we,
  input  logic [TMR_W-1:0] ld_data,
  input  logic [TMR_W-1:0] ld_mask,
  input  logic             tick,
  output logic [TMR_W-1:0] remain,
  output logic [TMR_W-1:0] count_up,
  output logic             expire
);
  logic [TMR_W-1:0] load_q, remain_q, next_period;
  logic             period_end;

  assign period_end  = tick && (remain_q == TMR_W'(1));
  assign next_period = (load_q == '0) ? '1 : (~load_q + TMR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q   <= '0;
      remain_q <= '1;
      expire   <= 1'b0;
    end else begin
      expire <= period_end;
      if (period_end)  remain_q <= next_period;
      else if (tick)   remain_q <= remain_q - TMR_W'(1);
      if (ld_we)           load_q <= (load_q & ~ld_mask) | (ld_data & ld_mask);
      else if (period_end) load_q <= '0;
    end
  end

  assign remain   = remain_q;
  assign count_up = ~remain_q + TMR_W'(1);
endmodule

// File: rtl/sys_status_timer.sv
module sys_status_timer import sst_pkg::*; #(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h2008_0000,
  parameter int          IDX_W     = 3,
  parameter int          FAR_W     = 15,
  parameter int          TMR_W     = 16,
  parameter logic        MEM_CODE0 = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              err_capture,
  input  logic [FAR_W-1:0]  err_addr,
  input  logic              us_tick,
  output logic              tmr_expire
);
  localparam int OFS_W = IDX_W + 2;
  localparam int NREG  = 1 << IDX_W;

  logic             hit, wr_hit, rd_hit;
  logic [IDX_W-1:0] idx;
  logic [LANES-1:0] lane_en;
  logic [DATA_W-1:0] wmask;
  logic [NREG-1:0]  wr_sel;

  assign hit    = (bus_addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
  assign idx    = bus_addr[OFS_W-1:2];
  assign wr_hit = bus_req && bus_wr && hit;
  assign rd_hit = bus_req && !bus_wr && hit;

  for (genvar g = 0; g < NREG; g++) begin : g_wsel
    assign wr_sel[g] = wr_hit && (idx == IDX_W'(g));
  end

  sst_lane_mask i_lane (
    .size    (bus_size),
    .addr_lo (bus_addr[1:0]),
    .lane_en (lane_en),
    .bit_mask(wmask)
  );

  // Plain read/write words
  logic [DATA_W-1:0] halt_q, led_q, pctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q <= '0;
      led_q  <= '0;
      pctl_q <= '0;
    end else begin
      if (wr_sel[REG_HALT]) halt_q <= lane_merge(halt_q, bus_wdata, wmask);
      if (wr_sel[REG_LED])  led_q  <= lane_merge(led_q,  bus_wdata, wmask);
      if (wr_sel[REG_PCTL]) pctl_q <= lane_merge(pctl_q, bus_wdata, wmask);
    end
  end

  logic [DATA_W-1:0] mse_value, far_value;
  logic              err_per;

  sst_err_bank #(
    .FAR_W    (FAR_W),
    .MEM_CODE0(MEM_CODE0)
  ) i_err (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_sel[REG_MSE]),
    .wdata    (bus_wdata),
    .wmask    (wmask),
    .capture  (err_capture),
    .cap_addr (err_addr),
    .mse_value(mse_value),
    .far_value(far_value),
    .per_flag (err_per)
  );

  logic [TMR_W-1:0] tmr_remain, tmr_count;

  sst_interval_timer #(
    .TMR_W(TMR_W)
  ) i_tmr (
    .clk     (clk),
    .rst     (rst),
    .ld_we   (wr_sel[REG_TIMER]),
    .ld_data (bus_wdata[DATA_W-1 -: TMR_W]),
    .ld_mask (wmask[DATA_W-1 -: TMR_W]),
    .tick    (us_tick),
    .remain  (tmr_remain),
    .count_up(tmr_count),
    .expire  (tmr_expire)
  );

  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    unique case (int'(idx))
      REG_HALT:  rd_val = halt_q;
      REG_MSE:   rd_val = mse_value;
      REG_FAR:   rd_val = far_value;
      REG_LED:   rd_val = led_q;
      REG_PCTL:  rd_val = pctl_q;
      REG_TIMER: rd_val = {tmr_count, {(DATA_W-TMR_W){1'b0}}};
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                       bus_rdata <= '0;
    else if (bus_req && !bus_wr)   bus_rdata <= rd_hit ? rd_val : '0;
  end
endmodule

// File: rtl/sst_checker.sv
module sst_checker #(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h2008_0000,
  parameter int          IDX_W     = 3,
  parameter int          TMR_W     = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              err_capture,
  input logic              us_tick,
  input logic              tmr_expire,
  input logic              per_flag,
  input logic [TMR_W-1:0]  tmr_remain
);
  logic       rd_in;
  logic [IDX_W-1:0] ridx;
  assign rd_in = bus_req && !bus_wr &&
                 (bus_addr[ADDR_W-1:IDX_W+2] == BASE_ADDR[ADDR_W-1:IDX_W+2]);
  assign ridx  = bus_addr[IDX_W+1:2];

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_in && (ridx == IDX_W'(3) || ridx == IDX_W'(6))) |=> (bus_rdata == 32'd0)); // R1
  AST_MSE_RD_MASK: assert property (@(posedge clk) disable iff (rst)
    (rd_in && ridx == IDX_W'(1)) |=> ((bus_rdata & ~32'h0000_0143) == 32'd0)); // R3
  AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (rst)
    err_capture |=> per_flag); // R5
  AST_FAR_RD_MASK: assert property (@(posedge clk) disable iff (rst)
    (rd_in && ridx == IDX_W'(2)) |=> (bus_rdata[31:15] == 17'd0)); // R6
  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !us_tick |=> $stable(tmr_remain)); // R9
  AST_REMAIN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    tmr_remain != '0); // R9
  AST_TIMER_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_in && ridx == IDX_W'(7)) |=> (bus_rdata[15:0] == 16'd0)); // R10
  AST_EXPIRE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    tmr_expire |-> $past(us_tick)); // R11
endmodule

bind sys_status_timer sst_checker #(
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR),
  .IDX_W    (IDX_W),
  .TMR_W    (TMR_W)
) i_sst_checker (
  .clk        (clk),
  .rst        (rst),
  .bus_req    (bus_req),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .err_capture(err_capture),
  .us_tick    (us_tick),
  .tmr_expire (tmr_expire),
  .per_flag   (err_per),
  .tmr_remain (tmr_remain)
);

// File: tb/test_sys_status_timer.sv
module test_sys_status_timer;
  localparam logic [31:0] BASE = 32'h2008_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        err_capture = 1'b0;
  logic [14:0] err_addr = '0;
  logic        us_tick = 1'b0;
  logic        tmr_expire;

  int vectors = 0, miscompares = 0, n_exp = 0;
  bit done = 0;

  // bench model of register contents
  logic [31:0] m_halt = 0, m_led = 0, m_pctl = 0;
  logic        m_pe = 0, m_wwp = 0, m_per = 0;
  logic [14:0] m_far = 0;

  always #10 clk = ~clk;

  sys_status_timer i_sys_status_timer (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .err_capture(err_capture), .err_addr(err_addr),
    .us_tick(us_tick), .tmr_expire(tmr_expire)
  );

  always @(negedge clk) if (!rst && tmr_expire) n_exp++;

  function automatic logic [31:0] lanes(input logic [1:0] sz, input logic [1:0] lo);
    logic [3:0] be;
    if (sz == 2'd0)      be = 4'b0001 << lo;
    else if (sz == 2'd1) be = lo[1] ? 4'b1100 : 4'b0011;
    else                 be = 4'b1111;
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] exp_read(input int idx);
    case (idx)
      0: return m_halt;
      1: return {23'd0, 1'b1, 1'b0, m_per, 4'd0, m_wwp, m_pe};
      2: return {17'd0, m_far};
      4: return m_led;
      5: return m_pctl;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata;
  endtask

  task automatic model_write(input int idx, input logic [1:0] sz, input logic [1:0] lo,
                             input logic [31:0] d);
    logic [31:0] m;
    m = lanes(sz, lo);
    case (idx)
      0: m_halt = (m_halt & ~m) | (d & m);
      1: begin
        if (m[0]) m_pe = d[0];
        if (m[1]) m_wwp = d[1];
        if (m[6] && d[6]) m_per = 0;
      end
      4: m_led = (m_led & ~m) | (d & m);
      5: m_pctl = (m_pctl & ~m) | (d & m);
      default: ;
    endcase
  endtask

  task automatic capture(input logic [14:0] a);
    @(negedge clk);
    err_capture = 1; err_addr = a;
    @(negedge clk);
    err_capture = 0;
    m_per = 1; m_far = a;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    us_tick = 1;
    repeat (n) @(negedge clk);
    us_tick = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    rst = 0;

    // R12: reset state
    for (int i = 0; i < 8; i++) begin
      bus_read(BASE + 32'(i * 4), r);
      check(i == 7 ? "R12 timer" : "R12 reset", r,
            i == 7 ? 32'h0001_0000 : exp_read(i));
    end

    // R2: byte lane write into lane 2 of LED word
    bus_write(BASE + 32'h12, 2'd0, 32'h00AB_0000);
    model_write(4, 2'd0, 2'd2, 32'h00AB_0000);
    bus_read(BASE + 32'h10, r);
    check("R2 byte lane", r, 32'h00AB_0000);
    // R2: upper word write into halt code
    bus_write(BASE + 32'h02, 2'd1, 32'h1234_5678);
    model_write(0, 2'd1, 2'd2, 32'h1234_5678);
    bus_read(BASE, r);
    check("R2 word lane", r, 32'h1234_0000);

    // R4: only bits 0 and 1 writable
    bus_write(BASE + 4, 2'd2, 32'hFFFF_FFBF);
    model_write(1, 2'd2, 2'd0, 32'hFFFF_FFBF);
    bus_read(BASE + 4, r);
    check("R4 mse write", r, 32'h0000_0103);

    // R5: capture sets flag and latches address
    capture(15'h5A5A);
    bus_read(BASE + 4, r);
    check("R5 flag set", r, 32'h0000_0143);
    bus_read(BASE + 8, r);
    check("R5 far latch", r, 32'h0000_5A5A);

    // R4: write 0 to bit 6 leaves flag, write 1 clears it
    bus_write(BASE + 4, 2'd2, 32'h0000_0003);
    model_write(1, 2'd2, 2'd0, 32'h0000_0003);
    bus_read(BASE + 4, r);
    check("R4 w0 keeps", r, 32'h0000_0143);
    bus_write(BASE + 4, 2'd2, 32'h0000_0040);
    model_write(1, 2'd2, 2'd0, 32'h0000_0040);
    bus_read(BASE + 4, r);
    check("R4 w1c", r, 32'h0000_0100);

    // R5: capture wins over a clear in the same cycle
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = BASE + 4; bus_size = 2'd2; bus_wdata = 32'h40;
    err_capture = 1; err_addr = 15'h0123;
    @(negedge clk);
    bus_req = 0; bus_wr = 0; err_capture = 0;
    m_per = 1; m_far = 15'h0123;
    bus_read(BASE + 4, r);
    check("R5 capture wins", r, 32'h0000_0140);

    // R6: failing address ignores writes
    bus_write(BASE + 8, 2'd2, 32'hFFFF_FFFF);
    bus_read(BASE + 8, r);
    check("R6 far write ignored", r, 32'h0000_0123);

    // R1: unused index and out-of-window writes have no effect
    bus_write(BASE + 32'h0C, 2'd2, 32'hDEAD_BEEF);
    bus_read(BASE + 32'h0C, r);
    check("R1 index 3 zero", r, 32'd0);
    bus_write(BASE + 32'h30, 2'd2, 32'hDEAD_BEEF);
    bus_read(BASE + 32'h10, r);
    check("R1 miss no write", r, m_led);
    bus_read(BASE + 32'h30, r);
    check("R1 miss reads zero", r, 32'd0);

    // R7 / R3 / R1: random register traffic with tick held low
    for (int it = 0; it < 400; it++) begin
      int op, idx;
      logic [1:0] sz, lo;
      logic [31:0] d;
      op  = $urandom_range(0, 4);
      idx = $urandom_range(0, 7);
      sz  = 2'($urandom_range(0, 3));
      lo  = 2'($urandom_range(0, 3));
      d   = $urandom();
      if (op <= 1) begin
        if (idx == 7) idx = 5;
        bus_write(BASE + 32'(idx * 4) + 32'(lo), sz, d);
        model_write(idx, sz, lo, d);
      end else if (op == 2) begin
        capture(15'(d));
      end else begin
        bus_read(BASE + 32'(idx * 4) + 32'(lo), r);
        check(idx == 7 ? "R10 timer static" : "R7 random read", r,
              idx == 7 ? 32'h0001_0000 : exp_read(idx));
      end
    end

    // Timer: R10 count after 9 ticks
    ticks(9);
    bus_read(BASE + 32'h1C, r);
    check("R10 count", r, 32'h000A_0000);
    // R8: load via upper word; current period unchanged
    bus_write(BASE + 32'h1E, 2'd1, 32'hFFF0_1234);
    bus_read(BASE + 32'h1C, r);
    check("R8 period kept", r, 32'h000A_0000);
    ticks(65525);
    check("R11 no early expire", 32'(n_exp), 32'd0);
    ticks(1);
    check("R11 expire pulse", {31'd0, tmr_expire}, 32'd1);
    @(negedge clk);
    check("R11 one cycle", {31'd0, tmr_expire}, 32'd0);
    // R9: new period 16 ticks from load 0xFFF0
    bus_read(BASE + 32'h1C, r);
    check("R9 reloaded period", r, 32'hFFF0_0000);
    ticks(15);
    bus_read(BASE + 32'h1C, r);
    check("R10 near wrap", r, 32'hFFFF_0000);
    check("R11 count", 32'(n_exp), 32'd1);
    ticks(1);
    check("R11 second pulse", {31'd0, tmr_expire}, 32'd1);
    // R9: load cleared, next period is 0xFFFF
    bus_read(BASE + 32'h1C, r);
    check("R9 load cleared", r, 32'h0001_0000);
    ticks(3);
    bus_read(BASE + 32'h1C, r);
    check("R9 full period", r, 32'h0004_0000);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule